// File: doc/BRIEF.md
# Transmit DMA Channel Control and Idle Status

This block holds the control state for a set of transmit DMA channels and reports their idle state to software. Every channel has its own configuration word, a credit counter and a read-only per-channel state word, laid out on a fixed stride. A shared read-only word gathers two per-channel idle flags: "buffers empty", taken from the transfer datapath, and "no pending request", derived from the channel's own request output.

Each channel gates the datapath's request wish (`ch_want`) against its run mode, its request-enable bit and its credit count. One request per cycle is granted while credit remains, and each grant uses one credit. A deferred pause lets a channel with a frame in progress run on until that frame's end-of-frame pulse, and then stop. End-of-descriptor events may raise per-channel interrupt causes. These causes are sticky and are cleared by writing ones, and any set cause drives one interrupt line.

Software stops a channel by writing zero to its configuration word. It then treats the channel as stopped only once both of that channel's bits in the shared word read as one.

Top module: `txdma_chan_ctrl`

## Requirements
- R1: After reset, every configuration word, credit counter and interrupt cause reads zero, `irq` is low and no channel requests.
- R2: A configuration write keeps only bits 31:30 (run mode), 21:20 (interrupt mode) and 3 (request enable). All other bits read back as zero.
- R3: With run mode 2'b10 and bit 3 set, a channel asserts `ch_req` in every cycle that `ch_want` is high and its credit is nonzero. Each such cycle lowers the credit by one. With bit 3 clear, the channel never requests and its credit is left unchanged.
- R4: A channel whose credit is zero does not request. A write to the credit counter in the same cycle as a grant loads the written value, and the grant does not decrement it.
- R5: Run mode 2'b00 or 2'b11 stops requests and deasserts `ch_active` in the cycle after the configuration write.
- R6: In run mode 2'b01, a channel with a frame in progress keeps requesting up to and including the cycle of its `ch_eof` pulse, and is inactive from the next cycle. A frame is in progress from its first grant until `ch_eof`. A channel in run mode 2'b01 with no frame in progress does not request.
- R7: The shared status word at 0x100 holds `ch_buf_empty[n]` at bit 24+n and the inverse of `ch_req[n]` at bit 16+n, with all other bits zero. Writes to this word have no effect.
- R8: Interrupt mode 2'b01 sets cause bit n on every `ch_desc_done[n]`. Mode 2'b10 sets it only when `ch_desc_irq[n]` is high in the same cycle. Modes 2'b00 and 2'b11 never set it. `irq` is high whenever any cause bit is set.
- R9: Writing the cause word at 0x104 clears each bit written as one and keeps each bit written as zero. A cause set in the same cycle as its clear stays set.
- R10: Channel n's configuration word is at 0x20*n, its credit at 0x20*n+0x4 and its state word at 0x20*n+0x8. The state word holds active at bit 0, frame in progress at bit 1 and buffers empty at bit 2. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ch_want | input | 8 | Datapath has a request to make, one bit per channel |
| ch_buf_empty | input | 8 | Datapath buffers of the channel are empty |
| ch_eof | input | 8 | End-of-frame pulse per channel |
| ch_desc_done | input | 8 | End-of-descriptor pulse per channel |
| ch_desc_irq | input | 8 | Descriptor asks for an interrupt, qualifies `ch_desc_done` |
| ch_req | output | 8 | Granted DMA request per channel |
| ch_active | output | 8 | Channel running (not paused) |
| irq | output | 1 | Host interrupt, high while any cause bit is set |

## Verification
Two pairs of functions can fall in the same cycle. In the first, an interrupt cause is raised on the same cycle that software clears it. The bench provokes this by pulsing a qualified end-of-descriptor in the cycle of a cause write that carries that channel's bit. It judges the result by reading the cause word and `irq` afterwards, which must still show the bit set. In the second, a credit load meets a grant: a credit write lands in a cycle where the channel is requesting, and the value read back immediately after must equal the written value, not that value minus one.

// File: rtl/txdma_pkg.sv
// Package: shared encodings and field positions for the transmit DMA
// channel control block. Assumes a 32-bit register word.
package txdma_pkg;

    typedef enum logic [1:0] {
        MODE_OFF       = 2'b00,
        MODE_PAUSE_EOF = 2'b01,
        MODE_RUN       = 2'b10,
        MODE_RSVD      = 2'b11
    } run_mode_e;

    typedef enum logic [1:0] {
        IRQ_NONE    = 2'b00,
        IRQ_EVERY   = 2'b01,
        IRQ_ON_FLAG = 2'b10,
        IRQ_RSVD    = 2'b11
    } irq_mode_e;

    localparam int MODE_LSB      = 30;
    localparam int IRQ_LSB       = 20;
    localparam int CREDIT_EN_BIT = 3;
    localparam logic [31:0] CFG_WMASK = 32'hC030_0008;

    localparam int EMPTY_LSB  = 24;
    localparam int NOPEND_LSB = 16;

endpackage

// File: rtl/txdma_chan.sv
// Module: one transmit DMA channel. It holds the channel's configuration word
// and credit counter, tracks whether a frame is in progress, gates the
// datapath request wish into a granted request and produces a one-cycle
// interrupt pulse per qualifying end-of-descriptor event.
// Assumes: the write strobes are one cycle wide; eof/desc_done are pulses.
module txdma_chan
    import txdma_pkg::*;
#(
    parameter int CREDIT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [31:0]         cfg_wdata,
    input  logic                crd_we,
    input  logic [CREDIT_W-1:0] crd_wdata,
    input  logic                want,
    input  logic                eof,
    input  logic                desc_done,
    input  logic                desc_flag,
    output logic [31:0]         cfg_q,
    output logic [CREDIT_W-1:0] credit_q,
    output logic                req,
    output logic                active,
    output logic                in_frame_q,
    output logic                irq_pulse
);

    run_mode_e mode;
    irq_mode_e imode;

    // Decode the stored mode fields.
    always_comb begin
        mode  = run_mode_e'(cfg_q[MODE_LSB +: 2]);
        imode = irq_mode_e'(cfg_q[IRQ_LSB +: 2]);
    end

    // Running state and request gating.
    always_comb begin
        active = (mode == MODE_RUN) || ((mode == MODE_PAUSE_EOF) && in_frame_q);
        req    = active && cfg_q[CREDIT_EN_BIT] && want && (credit_q != '0);
    end

    // Interrupt pulse selection by interrupt mode.
    always_comb begin
        irq_pulse = desc_done &&
                    ((imode == IRQ_EVERY) || ((imode == IRQ_ON_FLAG) && desc_flag));
    end

    // Configuration word: only the defined fields are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata & CFG_WMASK;
    end

    // Credit counter: a load wins over a grant decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)      credit_q <= '0;
        else if (crd_we) credit_q <= crd_wdata;
        else if (req)    credit_q <= credit_q - 1'b1;
    end

    // Frame tracking: opened by a grant, closed by eof, dropped when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      in_frame_q <= 1'b0;
        else if ((mode == MODE_OFF) || (mode == MODE_RSVD)) in_frame_q <= 1'b0;
        else if (eof)                                    in_frame_q <= 1'b0;
        else if (req)                                    in_frame_q <= 1'b1;
    end

    AST_GRANT_USES_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !crd_we) |=> (credit_q == CREDIT_W'($past(credit_q) - 1'b1)))
        else $error("grant did not consume one credit"); // R3

    AST_CREDIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !crd_we) |=> $stable(credit_q))
        else $error("credit changed without grant or load"); // R4

    AST_PAUSE_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_PAUSE_EOF) && eof && !cfg_we) |=> !active)
        else $error("channel still active after eof in deferred pause"); // R6

endmodule

// File: rtl/txdma_status.sv
// Module: shared idle status word and sticky interrupt causes. It packs the
// per-channel buffers-empty and no-pending-request flags into one word and
// keeps one write-one-to-clear cause bit per channel.
// Assumes: NUM_CH <= 8 so both flag groups fit their byte lanes.
module txdma_status
    import txdma_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_pulse,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_mask,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] buf_empty,
    output logic [31:0]       stat_word,
    output logic [NUM_CH-1:0] cause_q,
    output logic              irq_out
);

    logic [NUM_CH-1:0] clr_eff;

    // Pack both idle flag groups into the shared word.
    always_comb begin
        stat_word = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            stat_word[EMPTY_LSB + n]  = buf_empty[n];
            stat_word[NOPEND_LSB + n] = ~req[n];
        end
    end

    // Clear mask applies only on a cause-word write.
    always_comb clr_eff = clr_we ? clr_mask : '0;

    // Sticky causes: a new pulse wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr_eff) | irq_pulse;
    end

    // Single host interrupt line.
    always_comb irq_out = |cause_q;

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !clr_we) |=> irq_out)
        else $error("interrupt dropped without a clear"); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_pulse) |=> ((cause_q & $past(irq_pulse)) == $past(irq_pulse)))
        else $error("cause pulse lost"); // R9

endmodule

// File: rtl/txdma_chan_ctrl.sv
// Module: top of the transmit DMA channel control block. It decodes the
// register address space (channel words on a fixed stride, then the shared
// status and cause words), instantiates one channel per index and the shared
// status logic, and drives the combinational read data.
// Assumes: NUM_CH is a power of two, at least 2; the channel span is below
// STAT_ADDR.
module txdma_chan_ctrl
    import txdma_pkg::*;
#(
    parameter int              NUM_CH     = 8,
    parameter int              ADDR_W     = 9,
    parameter int              CREDIT_W   = 8,
    parameter int              STRIDE_LG2 = 5,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 9'h100,
    parameter logic [ADDR_W-1:0] CAUSE_ADDR = 9'h104
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] ch_want,
    input  logic [NUM_CH-1:0] ch_buf_empty,
    input  logic [NUM_CH-1:0] ch_eof,
    input  logic [NUM_CH-1:0] ch_desc_done,
    input  logic [NUM_CH-1:0] ch_desc_irq,
    output logic [NUM_CH-1:0] ch_req,
    output logic [NUM_CH-1:0] ch_active,
    output logic              irq
);

    localparam int CH_IDX_W = $clog2(NUM_CH);
    localparam logic [ADDR_W-1:0] CH_SPAN = ADDR_W'(NUM_CH << STRIDE_LG2);
    localparam logic [STRIDE_LG2-1:0] OFS_CFG = STRIDE_LG2'(0);
    localparam logic [STRIDE_LG2-1:0] OFS_CRD = STRIDE_LG2'(4);
    localparam logic [STRIDE_LG2-1:0] OFS_BUF = STRIDE_LG2'(8);

    logic                  in_ch;
    logic [CH_IDX_W-1:0]   ch_sel;
    logic [STRIDE_LG2-1:0] sub;
    logic [NUM_CH-1:0]     cfg_we, crd_we, in_frame, irq_pulse, cause;
    logic [31:0]           cfg_arr [NUM_CH];
    logic [CREDIT_W-1:0]   crd_arr [NUM_CH];
    logic [31:0]           stat_word;
    logic                  cause_we;

    // Address split into channel index and offset within the stride.
    always_comb begin
        in_ch    = reg_addr < CH_SPAN;
        ch_sel   = reg_addr[STRIDE_LG2 +: CH_IDX_W];
        sub      = reg_addr[STRIDE_LG2-1:0];
        cause_we = reg_we && (reg_addr == CAUSE_ADDR);
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        // Per-channel write strobes.
        assign cfg_we[n] = reg_we && in_ch && (ch_sel == CH_IDX_W'(n)) && (sub == OFS_CFG);
        assign crd_we[n] = reg_we && in_ch && (ch_sel == CH_IDX_W'(n)) && (sub == OFS_CRD);

        txdma_chan #(.CREDIT_W(CREDIT_W)) chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we[n]),
            .cfg_wdata  (reg_wdata),
            .crd_we     (crd_we[n]),
            .crd_wdata  (reg_wdata[CREDIT_W-1:0]),
            .want       (ch_want[n]),
            .eof        (ch_eof[n]),
            .desc_done  (ch_desc_done[n]),
            .desc_flag  (ch_desc_irq[n]),
            .cfg_q      (cfg_arr[n]),
            .credit_q   (crd_arr[n]),
            .req        (ch_req[n]),
            .active     (ch_active[n]),
            .in_frame_q (in_frame[n]),
            .irq_pulse  (irq_pulse[n])
        );
    end

    txdma_status #(.NUM_CH(NUM_CH)) status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_pulse (irq_pulse),
        .clr_we    (cause_we),
        .clr_mask  (reg_wdata[NUM_CH-1:0]),
        .req       (ch_req),
        .buf_empty (ch_buf_empty),
        .stat_word (stat_word),
        .cause_q   (cause),
        .irq_out   (irq)
    );

    // Read data multiplexer; unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        if (in_ch) begin
            case (sub)
                OFS_CFG: reg_rdata = cfg_arr[ch_sel];
                OFS_CRD: reg_rdata = 32'(crd_arr[ch_sel]);
                OFS_BUF: reg_rdata = {29'b0, ch_buf_empty[ch_sel],
                                      in_frame[ch_sel], ch_active[ch_sel]};
                default: reg_rdata = '0;
            endcase
        end else if (reg_addr == STAT_ADDR) begin
            reg_rdata = stat_word;
        end else if (reg_addr == CAUSE_ADDR) begin
            reg_rdata = 32'(cause);
        end
    end

    AST_STOP_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we[0] && (reg_wdata[MODE_LSB +: 2] == 2'b00)) |=> !ch_req[0])
        else $error("channel 0 requested after stop"); // R5

endmodule

// File: tb/txdma_chan_ctrl_tb_top.sv
module txdma_chan_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  ch_want = '0, ch_buf_empty = 8'hFF, ch_eof = '0;
    logic [7:0]  ch_desc_done = '0, ch_desc_irq = '0;
    logic [7:0]  ch_req, ch_active;
    logic        irq;

    int total = 0;
    int npass = 0;

    localparam logic [8:0] STAT  = 9'h100;
    localparam logic [8:0] CAUSE = 9'h104;

    always #5 clk = ~clk;

    txdma_chan_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_want(ch_want),
        .ch_buf_empty(ch_buf_empty), .ch_eof(ch_eof), .ch_desc_done(ch_desc_done),
        .ch_desc_irq(ch_desc_irq), .ch_req(ch_req), .ch_active(ch_active), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act === exp) npass++;
        else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [8:0] cfga(input int n);
        return 9'(n * 32);
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        @(negedge clk);
        rd(cfga(3), d);       chk("R1 cfg after reset", d, 0);
        rd(cfga(3) + 4, d);   chk("R1 credit after reset", d, 0);
        rd(CAUSE, d);         chk("R1 cause after reset", d, 0);
        chk("R1 irq after reset", {31'b0, irq}, 0);
        chk("R1 no requests after reset", {24'b0, ch_req}, 0);
        rd(STAT, d);          chk("R7 status after reset", d, 32'hFFFF_0000);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        wr(cfga(3), 32'hFFFF_FFFF);
        rd(cfga(3), d);       chk("R2 config field mask", d, 32'hC030_0008);
        wr(cfga(3), 32'h0);
    endtask

    task automatic t_addr;
        logic [31:0] d;
        wr(cfga(5) + 4, 32'h0000_002A);
        rd(cfga(5) + 4, d);   chk("R10 credit ch5 at 0xA4", d, 32'h2A);
        rd(cfga(4) + 4, d);   chk("R10 credit ch4 untouched", d, 0);
        rd(9'h00C, d);        chk("R10 unmapped read", d, 0);
        rd(cfga(5) + 8, d);   chk("R10 state word ch5", d, 32'h4);
        wr(cfga(5) + 4, 32'h0);
    endtask

    task automatic t_run;
        logic [31:0] d;
        int cnt;
        ch_want[0] = 1'b1;
        wr(cfga(0) + 4, 32'd3);
        wr(cfga(0), 32'h8000_0008);
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            if (ch_req[0]) cnt++;
            @(negedge clk);
        end
        chk("R3 grants equal credit", cnt, 3);
        rd(cfga(0) + 4, d);   chk("R4 credit exhausted", d, 0);
        chk("R4 no request at zero credit", {31'b0, ch_req[0]}, 0);
        wr(cfga(0), 32'h8000_0000);
        wr(cfga(0) + 4, 32'd2);
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            if (ch_req[0]) cnt++;
            @(negedge clk);
        end
        chk("R3 request enable clear blocks", cnt, 0);
        rd(cfga(0) + 4, d);   chk("R3 credit kept when disabled", d, 2);
        wr(cfga(0), 32'h0);
        ch_want[0] = 1'b0;
    endtask

    task automatic t_off;
        logic [31:0] d;
        ch_want[1] = 1'b1;
        wr(cfga(1) + 4, 32'd200);
        wr(cfga(1), 32'h8000_0008);
        chk("R3 ch1 requesting", {31'b0, ch_req[1]}, 1);
        rd(STAT, d);          chk("R7 pending bit low while requesting", d, 32'hFFFD_0000);
        wr(cfga(1), 32'h0);
        chk("R5 off stops request", {31'b0, ch_req[1]}, 0);
        chk("R5 off deasserts active", {31'b0, ch_active[1]}, 0);
        rd(STAT, d);          chk("R7 idle after stop", d, 32'hFFFF_0000);
        wr(cfga(1), 32'hC000_0008);
        chk("R5 reserved mode no request", {31'b0, ch_req[1]}, 0);
        wr(cfga(1), 32'h0);
        ch_want[1] = 1'b0;
    endtask

    task automatic t_pause_eof;
        logic [31:0] d;
        int cnt;
        ch_want[2] = 1'b1;
        wr(cfga(2) + 4, 32'd200);
        wr(cfga(2), 32'h8000_0008);
        @(negedge clk);
        wr(cfga(2), 32'h4000_0008);
        cnt = 0;
        for (int i = 0; i < 3; i++) begin
            if (ch_req[2] && ch_active[2]) cnt++;
            @(negedge clk);
        end
        chk("R6 runs on inside frame", cnt, 3);
        ch_eof[2] = 1'b1;
        #1;
        chk("R6 requests in eof cycle", {31'b0, ch_req[2]}, 1);
        @(negedge clk);
        ch_eof[2] = 1'b0;
        chk("R6 stopped after eof", {31'b0, ch_req[2]}, 0);
        chk("R6 inactive after eof", {31'b0, ch_active[2]}, 0);
        rd(STAT, d);          chk("R7 idle after deferred pause", d, 32'hFFFF_0000);
        wr(cfga(2), 32'h0);
        ch_want[2] = 1'b0;
        wr(cfga(6) + 4, 32'd10);
        wr(cfga(6), 32'h4000_0008);
        ch_want[6] = 1'b1;
        @(negedge clk);
        chk("R6 no frame so no request", {31'b0, ch_req[6]}, 0);
        ch_want[6] = 1'b0;
        wr(cfga(6), 32'h0);
    endtask

    task automatic t_status;
        logic [31:0] d;
        ch_buf_empty = 8'h5A;
        wr(STAT, 32'hFFFF_FFFF);
        rd(STAT, d);          chk("R7 status packing and write ignored", d, 32'h5AFF_0000);
        ch_buf_empty = 8'hFF;
    endtask

    task automatic pulse_done(input logic flag);
        @(negedge clk);
        ch_desc_done[4] = 1'b1; ch_desc_irq[4] = flag;
        @(negedge clk);
        ch_desc_done[4] = 1'b0; ch_desc_irq[4] = 1'b0;
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(cfga(4), 32'h0010_0000);
        pulse_done(1'b0);
        chk("R8 every-descriptor irq", {31'b0, irq}, 1);
        rd(CAUSE, d);         chk("R8 cause bit ch4", d, 32'h10);
        wr(CAUSE, 32'h0);
        chk("R9 zero write keeps cause", {31'b0, irq}, 1);
        wr(CAUSE, 32'h10);
        chk("R9 one write clears cause", {31'b0, irq}, 0);
        wr(cfga(4), 32'h0020_0000);
        pulse_done(1'b0);
        chk("R8 flag mode ignores unflagged", {31'b0, irq}, 0);
        pulse_done(1'b1);
        chk("R8 flag mode fires on flag", {31'b0, irq}, 1);
        wr(CAUSE, 32'h10);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = CAUSE; reg_wdata = 32'h10;
        ch_desc_done[4] = 1'b1; ch_desc_irq[4] = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; ch_desc_done[4] = 1'b0; ch_desc_irq[4] = 1'b0;
        rd(CAUSE, d);         chk("R9 set wins over clear", d, 32'h10);
        chk("R9 irq held after race", {31'b0, irq}, 1);
        wr(CAUSE, 32'h10);
        wr(cfga(4), 32'h0);
        pulse_done(1'b1);
        chk("R8 no-interrupt mode", {31'b0, irq}, 0);
    endtask

    task automatic t_credit_race;
        logic [31:0] d;
        ch_want[7] = 1'b1;
        wr(cfga(7) + 4, 32'd5);
        wr(cfga(7), 32'h8000_0008);
        chk("R3 ch7 requesting", {31'b0, ch_req[7]}, 1);
        wr(cfga(7) + 4, 32'd9);
        rd(cfga(7) + 4, d);   chk("R4 load wins over grant", d, 9);
        ch_want[7] = 1'b0;
        wr(cfga(7), 32'h0);
    endtask

    initial begin
        #2_000_000;
        total++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", npass, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_addr();
        t_run();
        t_off();
        t_pause_eof();
        t_status();
        t_irq();
        t_credit_race();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", npass, total);
        $finish;
    end

endmodule